// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses whether a conditional branch will be taken. Two component predictors run side by side. The first is per-branch: a table indexed by fetch address keeps each branch's own recent outcome pattern, and that pattern selects a 3-bit saturating counter. The second is global: a 12-bit register of recent branch directions selects a 2-bit saturating counter. A third table of 2-bit counters, indexed by the same global history, decides for each lookup which of the two components supplies the final answer.

The fetch side presents a PC and gets back, in the same cycle, the final direction, both component guesses, the chooser's pick, the per-branch table index and the global history used. When a lookup is marked valid, the global history shifts in the final guess speculatively. When the branch later resolves, the execution side returns the PC, the real outcome, the three guesses made at fetch and the global history captured at fetch. Resolution trains all three counter tables and the branch's own pattern, and a wrong final guess rewinds the global history to the captured value extended by the real outcome.

Top module: `tourney_predictor`

## Requirements
- R1: After reset every per-branch pattern and the global history are zero, per-branch counters hold 3 (weakly not-taken), global counters hold 1 (weakly not-taken) and chooser counters hold 1 (weakly favouring global), so any lookup returns not-taken with `pred_use_local` low.
- R2: The per-branch table index is PC bits [11:2] and appears on `pred_lidx`; the per-branch guess is the MSB of the 3-bit counter selected by that branch's 10-bit pattern, so two branches with equal patterns share one counter.
- R3: The global guess is the MSB of the 2-bit counter selected by the current global history, which appears on `pred_ghist`.
- R4: The chooser counter selected by the global history picks the per-branch guess when its value is 2 or 3 (`pred_use_local` high) and the global guess otherwise; `pred_taken` equals the picked guess.
- R5: On resolve, the branch's pattern shifts left by one with the real outcome entering bit 0 (1 = taken).
- R6: On resolve, the per-branch counter selected by the branch's pattern as it stood before that resolve's shift counts up on taken and down on not-taken, saturating at 0 and 7.
- R7: On resolve, the global counter at the returned fetch-time history counts up on taken and down on not-taken, saturating at 0 and 3.
- R8: On resolve, the chooser counter at the returned fetch-time history changes only when the two returned component guesses differ: up (toward per-branch) when the per-branch guess matched the outcome, down otherwise, saturating at 0 and 3.
- R9: In a cycle with a valid lookup and no rewind, the global history shifts left with `pred_taken` entering bit 0.
- R10: A resolve whose returned final guess differs from the outcome sets the global history to the returned history shifted left with the outcome in bit 0, taking precedence over a lookup in the same cycle; a correct resolve leaves the history alone.
- R11: While `res_valid` and `pred_valid` are both low, no table or history changes, whatever the other inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pred_valid | input | 1 | Lookup is real; shifts the global history speculatively |
| pred_pc | input | 32 | Fetch PC of the branch being looked up |
| pred_taken | output | 1 | Final direction guess |
| pred_use_local | output | 1 | Chooser picked the per-branch guess |
| pred_local_taken | output | 1 | Per-branch component guess |
| pred_global_taken | output | 1 | Global component guess |
| pred_lidx | output | 10 | Per-branch table index used |
| pred_ghist | output | 12 | Global history used for this lookup |
| res_valid | input | 1 | A branch is resolving this cycle |
| res_pc | input | 32 | PC of the resolving branch |
| res_taken | input | 1 | Real outcome |
| res_pred_taken | input | 1 | Final guess made at fetch |
| res_local_taken | input | 1 | Per-branch guess made at fetch |
| res_global_taken | input | 1 | Global guess made at fetch |
| res_ghist | input | 12 | Global history captured at fetch |

## Verification
The assertions watch, every cycle, that counter tables never wrap past their bounds, that a resolve leaves the newest outcome in bit 0 of the branch's pattern, and that the global history follows either the speculative shift or the rewind with the rewind winning. Only the bench scenarios can show that the right counter is trained: that a per-branch counter is reached through the pattern as it was before the shift, that two branches with equal patterns share it, that the chooser ignores agreeing resolves and that the final guess really switches source as the chooser moves, and that inputs carried without a valid strobe change nothing.

// File: rtl/tp_pkg.sv
package tp_pkg;

    localparam int DEF_PC_W    = 32;
    localparam int DEF_LIDX_W  = 10;
    localparam int DEF_LHIST_W = 10;
    localparam int DEF_LCTR_W  = 3;
    localparam int DEF_GHIST_W = 12;
    localparam int DEF_GCTR_W  = 2;
    localparam int DEF_CHS_W   = 2;

    typedef enum logic {
        PICK_GLOBAL = 1'b0,
        PICK_LOCAL  = 1'b1
    } pick_e;

    // value just below the taken threshold of a w-bit counter
    function automatic int weak_low(input int w);
        return (1 << (w - 1)) - 1;
    endfunction

    function automatic int ctr_top(input int w);
        return (1 << w) - 1;
    endfunction

endpackage

// File: rtl/tp_ctr_table.sv
module tp_ctr_table #(
    parameter int IDX_W     = 12,
    parameter int CTR_W     = 2,
    parameter int RESET_VAL = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [CTR_W-1:0] rd_val,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic             upd_up
);
    localparam int DEPTH = 1 << IDX_W;
    localparam logic [CTR_W-1:0] TOP  = CTR_W'(tp_pkg::ctr_top(CTR_W));
    localparam logic [CTR_W-1:0] INIT = CTR_W'(RESET_VAL);

    logic [CTR_W-1:0] mem [DEPTH];
    logic [CTR_W-1:0] cur, nxt;

    assign rd_val = mem[rd_idx];
    assign cur    = mem[upd_idx];

    always_comb begin
        nxt = cur;
        if (upd_up && cur != TOP)
            nxt = cur + 1'b1;
        else if (!upd_up && cur != '0)
            nxt = cur - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= INIT;
        end else if (upd_en) begin
            mem[upd_idx] <= nxt;
        end
    end

    // R6 R7 R8: counters stop at their bounds
    assert_ctr_ceiling_R7: assert property (@(posedge clk) disable iff (rst)
        (upd_en && upd_up && mem[upd_idx] == TOP) |=> mem[$past(upd_idx)] == TOP);
    assert_ctr_floor_R7: assert property (@(posedge clk) disable iff (rst)
        (upd_en && !upd_up && mem[upd_idx] == '0) |=> mem[$past(upd_idx)] == '0);

endmodule

// File: rtl/tp_local_pred.sv
module tp_local_pred #(
    parameter int LIDX_W  = 10,
    parameter int LHIST_W = 10,
    parameter int LCTR_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LIDX_W-1:0] rd_lidx,
    output logic              rd_taken,
    input  logic              upd_en,
    input  logic [LIDX_W-1:0] upd_lidx,
    input  logic              upd_taken
);
    localparam int NBR = 1 << LIDX_W;

    logic [LHIST_W-1:0] pattern [NBR];
    logic [LHIST_W-1:0] rd_pat, upd_pat;
    logic [LCTR_W-1:0]  ctr_val;

    assign rd_pat  = pattern[rd_lidx];
    assign upd_pat = pattern[upd_lidx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NBR; i++) pattern[i] <= '0;
        end else if (upd_en) begin
            pattern[upd_lidx] <= {upd_pat[LHIST_W-2:0], upd_taken};
        end
    end

    // counter is trained through the pattern held before this resolve's shift
    tp_ctr_table #(
        .IDX_W    (LHIST_W),
        .CTR_W    (LCTR_W),
        .RESET_VAL(tp_pkg::weak_low(LCTR_W))
    ) u_lctr (
        .clk    (clk),
        .rst    (rst),
        .rd_idx (rd_pat),
        .rd_val (ctr_val),
        .upd_en (upd_en),
        .upd_idx(upd_pat),
        .upd_up (upd_taken)
    );

    assign rd_taken = ctr_val[LCTR_W-1];

    assert_pattern_newest_R5: assert property (@(posedge clk) disable iff (rst)
        upd_en |=> pattern[$past(upd_lidx)][0] == $past(upd_taken));

endmodule

// File: rtl/tp_ghist.sv
module tp_ghist #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         spec_en,
    input  logic         spec_taken,
    input  logic         fix_en,
    input  logic [W-1:0] fix_base,
    input  logic         fix_taken,
    output logic [W-1:0] hist
);
    logic unused_base_msb;
    assign unused_base_msb = fix_base[W-1];

    always_ff @(posedge clk) begin
        if (rst)
            hist <= '0;
        else if (fix_en)
            hist <= {fix_base[W-2:0], fix_taken};
        else if (spec_en)
            hist <= {hist[W-2:0], spec_taken};
    end

    assert_hist_rewind_R10: assert property (@(posedge clk) disable iff (rst)
        fix_en |=> hist == {$past(fix_base[W-2:0]), $past(fix_taken)});
    assert_hist_spec_R9: assert property (@(posedge clk) disable iff (rst)
        (spec_en && !fix_en) |=> (hist[W-1:1] == $past(hist[W-2:0]))
                                 && (hist[0] == $past(spec_taken)));

endmodule

// File: rtl/tourney_predictor.sv
module tourney_predictor #(
    parameter int PC_W    = tp_pkg::DEF_PC_W,
    parameter int LIDX_W  = tp_pkg::DEF_LIDX_W,
    parameter int LHIST_W = tp_pkg::DEF_LHIST_W,
    parameter int LCTR_W  = tp_pkg::DEF_LCTR_W,
    parameter int GHIST_W = tp_pkg::DEF_GHIST_W,
    parameter int GCTR_W  = tp_pkg::DEF_GCTR_W,
    parameter int CHS_W   = tp_pkg::DEF_CHS_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               pred_valid,
    input  logic [PC_W-1:0]    pred_pc,
    output logic               pred_taken,
    output logic               pred_use_local,
    output logic               pred_local_taken,
    output logic               pred_global_taken,
    output logic [LIDX_W-1:0]  pred_lidx,
    output logic [GHIST_W-1:0] pred_ghist,
    input  logic               res_valid,
    input  logic [PC_W-1:0]    res_pc,
    input  logic               res_taken,
    input  logic               res_pred_taken,
    input  logic               res_local_taken,
    input  logic               res_global_taken,
    input  logic [GHIST_W-1:0] res_ghist
);
    import tp_pkg::*;

    localparam int LIDX_LO = 2;
    localparam int LIDX_HI = LIDX_LO + LIDX_W - 1;

    logic [LIDX_W-1:0]  res_lidx;
    logic [GHIST_W-1:0] ghist;
    logic [GCTR_W-1:0]  gctr_val;
    logic [CHS_W-1:0]   chs_val;
    logic               mispredict;
    logic               chs_train;
    pick_e              pick;

    logic unused_pc_bits;
    assign unused_pc_bits = ^{pred_pc[PC_W-1:LIDX_HI+1], pred_pc[LIDX_LO-1:0],
                              res_pc[PC_W-1:LIDX_HI+1],  res_pc[LIDX_LO-1:0]};

    assign pred_lidx  = pred_pc[LIDX_HI:LIDX_LO];
    assign res_lidx   = res_pc[LIDX_HI:LIDX_LO];
    assign pred_ghist = ghist;
    assign mispredict = res_valid && (res_pred_taken != res_taken);
    assign chs_train  = res_valid && (res_local_taken != res_global_taken);

    tp_local_pred #(
        .LIDX_W (LIDX_W),
        .LHIST_W(LHIST_W),
        .LCTR_W (LCTR_W)
    ) u_local (
        .clk      (clk),
        .rst      (rst),
        .rd_lidx  (pred_lidx),
        .rd_taken (pred_local_taken),
        .upd_en   (res_valid),
        .upd_lidx (res_lidx),
        .upd_taken(res_taken)
    );

    tp_ctr_table #(
        .IDX_W    (GHIST_W),
        .CTR_W    (GCTR_W),
        .RESET_VAL(weak_low(GCTR_W))
    ) u_gctr (
        .clk    (clk),
        .rst    (rst),
        .rd_idx (ghist),
        .rd_val (gctr_val),
        .upd_en (res_valid),
        .upd_idx(res_ghist),
        .upd_up (res_taken)
    );

    tp_ctr_table #(
        .IDX_W    (GHIST_W),
        .CTR_W    (CHS_W),
        .RESET_VAL(weak_low(CHS_W))
    ) u_chooser (
        .clk    (clk),
        .rst    (rst),
        .rd_idx (ghist),
        .rd_val (chs_val),
        .upd_en (chs_train),
        .upd_idx(res_ghist),
        .upd_up (res_local_taken == res_taken)
    );

    assign pred_global_taken = gctr_val[GCTR_W-1];
    assign pick              = chs_val[CHS_W-1] ? PICK_LOCAL : PICK_GLOBAL;
    assign pred_use_local    = (pick == PICK_LOCAL);
    assign pred_taken        = (pick == PICK_LOCAL) ? pred_local_taken : pred_global_taken;

    tp_ghist #(.W(GHIST_W)) u_ghist (
        .clk       (clk),
        .rst       (rst),
        .spec_en   (pred_valid),
        .spec_taken(pred_taken),
        .fix_en    (mispredict),
        .fix_base  (res_ghist),
        .fix_taken (res_taken),
        .hist      (ghist)
    );

endmodule

// File: tb/tourney_predictor_test.sv
`timescale 1ns/1ps
module tourney_predictor_test;

    localparam logic [31:0] PC_A = 32'h40;
    localparam logic [31:0] PC_B = 32'h80;
    localparam logic [31:0] PC_C = 32'h100;
    localparam logic [31:0] PC_D = 32'h200;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pred_valid = 1'b0;
    logic [31:0] pred_pc = '0;
    logic        pred_taken, pred_use_local, pred_local_taken, pred_global_taken;
    logic [9:0]  pred_lidx;
    logic [11:0] pred_ghist;
    logic        res_valid = 1'b0;
    logic [31:0] res_pc = '0;
    logic        res_taken = 1'b0, res_pred_taken = 1'b0;
    logic        res_local_taken = 1'b0, res_global_taken = 1'b0;
    logic [11:0] res_ghist = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tourney_predictor uut (
        .clk(clk), .rst(rst),
        .pred_valid(pred_valid), .pred_pc(pred_pc),
        .pred_taken(pred_taken), .pred_use_local(pred_use_local),
        .pred_local_taken(pred_local_taken), .pred_global_taken(pred_global_taken),
        .pred_lidx(pred_lidx), .pred_ghist(pred_ghist),
        .res_valid(res_valid), .res_pc(res_pc), .res_taken(res_taken),
        .res_pred_taken(res_pred_taken), .res_local_taken(res_local_taken),
        .res_global_taken(res_global_taken), .res_ghist(res_ghist)
    );

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic resolve(input logic [31:0] pc, input logic t, input logic pt,
                           input logic lp, input logic gp, input logic [11:0] gh);
        @(negedge clk);
        res_pc = pc; res_taken = t; res_pred_taken = pt;
        res_local_taken = lp; res_global_taken = gp; res_ghist = gh;
        res_valid = 1'b1;
        @(negedge clk);
        res_valid = 1'b0;
    endtask

    task automatic peek(input logic [31:0] pc);
        pred_pc = pc;
        #1;
    endtask

    task automatic t_reset;
        peek(PC_A);
        check("R1 pred_taken after reset", pred_taken, 0);
        check("R1 use_local after reset", pred_use_local, 0);
        check("R1 local guess after reset", pred_local_taken, 0);
        check("R1 global guess after reset", pred_global_taken, 0);
        check("R1 ghist after reset", pred_ghist, 0);
        check("R2 lidx from pc[11:2]", pred_lidx, 10'h010);
    endtask

    task automatic t_local;
        for (int i = 0; i < 10; i++) resolve(PC_A, 1, 1, 1, 1, 12'hABC);
        peek(PC_A);
        check("R5 full pattern reaches untrained counter", pred_local_taken, 0);
        resolve(PC_A, 1, 1, 1, 1, 12'hABC);
        peek(PC_A);
        check("R6 counter at pattern 3FF raised to taken", pred_local_taken, 1);
        for (int i = 0; i < 10; i++) resolve(PC_B, 1, 1, 1, 1, 12'hABC);
        peek(PC_B);
        check("R2 equal pattern shares counter", pred_local_taken, 1);
        resolve(PC_B, 0, 0, 0, 0, 12'hABC);
        peek(PC_A);
        check("R6 trained through pre-shift pattern", pred_local_taken, 0);
        check("R10 correct resolve keeps ghist", pred_ghist, 0);
    endtask

    task automatic t_global;
        resolve(PC_C, 1, 1, 1, 1, 12'h155);
        resolve(PC_C, 1, 0, 0, 0, 12'h0AA);
        peek(PC_C);
        check("R10 rewind ghist", pred_ghist, 12'h155);
        check("R3 global counter raised", pred_global_taken, 1);
        for (int i = 0; i < 3; i++) resolve(PC_C, 1, 1, 1, 1, 12'h155);
        resolve(PC_C, 0, 0, 0, 0, 12'h155);
        peek(PC_C);
        check("R7 ceiling then one step down", pred_global_taken, 1);
        resolve(PC_C, 0, 0, 0, 0, 12'h155);
        peek(PC_C);
        check("R7 second step down", pred_global_taken, 0);
    endtask

    task automatic t_chooser;
        peek(PC_C);
        check("R8 chooser untouched by agreeing resolves", pred_use_local, 0);
        resolve(PC_C, 1, 1, 1, 0, 12'h155);
        peek(PC_A);
        check("R8 chooser moves toward local", pred_use_local, 1);
        check("R3 global guess at 155", pred_global_taken, 1);
        check("R4 final follows local", pred_taken, 0);
        resolve(PC_C, 1, 1, 0, 0, 12'h155);
        peek(PC_A);
        check("R8 no train on agreement", pred_use_local, 1);
        resolve(PC_C, 0, 0, 1, 0, 12'h155);
        peek(PC_A);
        check("R8 chooser moves toward global", pred_use_local, 0);
        check("R4 final follows global", pred_taken, 1);
    endtask

    task automatic t_spec;
        @(negedge clk);
        pred_pc = PC_A; pred_valid = 1'b1;
        @(negedge clk);
        pred_valid = 1'b0;
        #1;
        check("R9 speculative shift of taken", pred_ghist, 12'h2AB);
        check("R9 guess at 2AB", pred_taken, 0);
        @(negedge clk);
        pred_valid = 1'b1;
        @(negedge clk);
        pred_valid = 1'b0;
        #1;
        check("R9 speculative shift of not-taken", pred_ghist, 12'h556);
    endtask

    task automatic t_priority;
        @(negedge clk);
        pred_pc = PC_A; pred_valid = 1'b1;
        res_pc = PC_D; res_taken = 0; res_pred_taken = 1;
        res_local_taken = 0; res_global_taken = 0; res_ghist = 12'h0F0;
        res_valid = 1'b1;
        @(negedge clk);
        pred_valid = 1'b0; res_valid = 1'b0;
        #1;
        check("R10 rewind wins over same-cycle lookup", pred_ghist, 12'h1E0);
    endtask

    task automatic t_idle;
        @(negedge clk);
        res_pc = PC_A; res_taken = 1; res_pred_taken = 0;
        res_local_taken = 1; res_global_taken = 0; res_ghist = 12'h1E0;
        res_valid = 1'b0; pred_valid = 1'b0; pred_pc = PC_A;
        repeat (4) @(negedge clk);
        #1;
        check("R11 ghist unchanged without strobes", pred_ghist, 12'h1E0);
        check("R11 chooser unchanged without strobes", pred_use_local, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_local();
        t_global();
        t_chooser();
        t_spec();
        t_priority();
        t_idle();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule